// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block turns a memory controller's column commands into one column address per clock for the length of an SDRAM read or write burst. A small mode word sets the burst length, the address ordering (linear or XOR-interleaved) and an option that shortens every write to a single beat. After a command is accepted, the block shows the column for each beat on `col_out` with `col_valid` high. `col_last` marks the final beat of a burst of fixed length.

Open-ended (full-page) bursts walk the whole 2^COL_W column space, wrapping to zero, until a stop request or a new command ends them. A new command may arrive on any cycle. It cuts the running burst short at once, so a controller can issue a fresh column every clock for random access. Row activation, precharge, refresh, data-path drive and CAS latency are handled elsewhere. This block only produces the column sequence.

Top module: `burst_col_seq`

## Requirements
- R1: A synchronous active-low reset leaves the block idle: `col_valid` and `col_last` are 0 and `col_out` is 0 from the first clock with `rst_n` low. Whenever `col_valid` is 0, `col_out` is 0 and `col_last` is 0.
- R2: `mode_in[2:0]` sets the burst length: 000 gives 1 beat, 001 gives 2, 010 gives 4, 011 gives 8 and 111 gives full page. The reserved codes 100, 101 and 110 each behave as a length of 1.
- R3: A command sampled with `cmd_valid` high at one clock edge shows its first beat after that edge. A fixed-length burst of L beats keeps `col_valid` high for exactly L cycles. `col_last` is high only on the L-th beat, and the block is idle the cycle after it unless a new command came in.
- R4: With `mode_in[3]`=0 (sequential), beat k has column `(start & ~(L-1)) | ((start + k) & (L-1))`. The burst counts up and wraps inside its aligned block, and the upper bits stay fixed. For example, start 3 with L=8 gives 3,4,5,6,7,0,1,2.
- R5: With `mode_in[3]`=1 (interleaved), beat k has column `(start & ~(L-1)) | ((start ^ k) & (L-1))`. With L=8, start 0 gives 0..7 and start 7 gives 7 down to 0. For L of 1 or 2 the order is the same as sequential.
- R6: A full-page burst begins at the start column and adds 1 each cycle, going from 2^COL_W-1 to 0. It ignores `mode_in[3]`, never raises `col_last`, and runs until a stop request or a new command ends it.
- R7: `stop_req` sampled high during a full-page burst makes `col_valid` 0 from the next cycle. During a fixed-length burst it has no effect.
- R8: A command sampled during a burst ends that burst. The next cycle shows beat 0 of the new burst from the new `cmd_col`, even when commands come on consecutive cycles.
- R9: With `mode_in[4]`=1, a write command (`cmd_write`=1) makes a one-beat burst. Read commands (`cmd_write`=0) keep the programmed length, including full page.
- R10: A mode word loaded with `mode_we` applies only to bursts whose command is sampled at a later edge. A burst already running keeps its settings. A command sampled at the same edge as a load uses the previous mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_we | input | 1 | Load `mode_in` into the mode register |
| mode_in | input | 5 | Mode word: [2:0] length code, [3] interleave, [4] single-beat writes |
| cmd_valid | input | 1 | Read or write command present this cycle |
| cmd_write | input | 1 | 1 for write command, 0 for read |
| cmd_col | input | COL_W | Starting column of the command |
| stop_req | input | 1 | Burst stop request (full page only) |
| col_out | output | COL_W | Column of the current beat, 0 when idle |
| col_valid | output | 1 | A beat is present this cycle |
| col_last | output | 1 | Current beat is the last of a fixed-length burst |

## Verification
The bench uses start columns that sit in the middle of an aligned block and near its top. A design that wraps across the block boundary, or that lets the low-bit arithmetic carry into the upper bits, would then show wrong columns such as 48 instead of 40. Interleaved starts of 7, 2 and 1 separate an XOR from an addition, which would give an ascending sequence where a descending or swapped one is due. Full-page bursts are started close to the top column to check the wrap to 0 and to check that `col_last` never rises. Stop requests during fixed-length bursts, commands on back-to-back cycles, and mode loads in the middle of a burst or at the same edge as a command catch a design that honours stop in every mode, lets a burst run on after an interrupt, or applies a new mode to a burst that has already started.

// File: rtl/bcs_pkg.sv
// Package: shared mode-word layout and decode for the burst column sequencer.
// Assumes a 5-bit mode word: [2:0] length code, [3] interleave, [4] write single.
package bcs_pkg;

    localparam int MODE_W = 5;

    // Decoded burst settings held by the mode register and by each burst.
    typedef struct packed {
        logic       full;       // open-ended page burst
        logic [1:0] len_log;    // log2 of fixed burst length
        logic       ilv;        // interleaved ordering
        logic       wr_single;  // writes are one beat
    } bcs_mode_t;

    // Turn the raw mode word into burst settings; reserved codes act as one beat.
    function automatic bcs_mode_t decode_mode(input logic [MODE_W-1:0] w);
        bcs_mode_t m;
        m.wr_single = w[4];
        m.ilv       = w[3];
        m.full      = 1'b0;
        m.len_log   = 2'd0;
        case (w[2:0])
            3'b001:  m.len_log = 2'd1;
            3'b010:  m.len_log = 2'd2;
            3'b011:  m.len_log = 2'd3;
            3'b111:  m.full    = 1'b1;
            default: m.len_log = 2'd0;
        endcase
        return m;
    endfunction

    // Index of the final beat for a fixed burst of 2**len_log beats.
    function automatic logic [3:0] beat_limit(input logic [1:0] len_log);
        return (4'd1 << len_log) - 4'd1;
    endfunction

endpackage

// File: rtl/bcs_mode_reg.sv
// Module: mode register. Holds the decoded mode word; loads on mode_we.
// Assumes synchronous active-low reset; reset mode is one-beat sequential.
module bcs_mode_reg
    import bcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_in,
    output bcs_mode_t         mode_q
);

    // Capture decoded settings whenever software loads a new word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (mode_we) begin
            mode_q <= decode_mode(mode_in);
        end
    end

endmodule

// File: rtl/bcs_beat_ctrl.sv
// Module: burst beat controller. Starts a burst on each command, counts
// beats, ends fixed bursts after the last beat and full-page bursts on stop.
// Assumes COL_W >= 4 so the beat counter can hold the fixed-burst limit.
module bcs_beat_ctrl
    import bcs_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  bcs_mode_t        mode_q,
    input  logic             cmd_valid,
    input  logic             cmd_write,
    input  logic [COL_W-1:0] cmd_col,
    input  logic             stop_req,
    output logic             active,
    output logic             last,
    output logic [COL_W-1:0] base,
    output logic [COL_W-1:0] cnt,
    output logic [1:0]       len_log,
    output logic             full,
    output logic             ilv
);

    logic             single;
    logic             eff_full;
    logic [1:0]       eff_len;
    logic [COL_W-1:0] cnt_nxt;

    // Settings the next burst would use, with write-single folded in.
    always_comb begin
        single   = cmd_write & mode_q.wr_single;
        eff_full = mode_q.full & ~single;
        eff_len  = single ? 2'd0 : mode_q.len_log;
        cnt_nxt  = cnt + COL_W'(1);
    end

    // Burst state: start, advance, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            last    <= 1'b0;
            base    <= '0;
            cnt     <= '0;
            len_log <= 2'd0;
            full    <= 1'b0;
            ilv     <= 1'b0;
        end else if (cmd_valid) begin
            active  <= 1'b1;
            base    <= cmd_col;
            cnt     <= '0;
            full    <= eff_full;
            len_log <= eff_len;
            ilv     <= mode_q.ilv & ~eff_full;
            last    <= ~eff_full && (eff_len == 2'd0);
        end else if (active) begin
            if ((stop_req && full) || last) begin
                active <= 1'b0;
                last   <= 1'b0;
            end else begin
                cnt  <= cnt_nxt;
                last <= ~full && (cnt_nxt == COL_W'(beat_limit(len_log)));
            end
        end
    end

endmodule

// File: rtl/bcs_col_gen.sv
// Module: column generator. Combines the burst start column with the beat
// count, by addition or XOR, inside the aligned block of the burst length.
// Assumes cnt stays below the burst length for fixed bursts.
module bcs_col_gen #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] cnt,
    input  logic [1:0]       len_log,
    input  logic             full,
    input  logic             ilv,
    output logic [COL_W-1:0] col
);

    logic [COL_W-1:0] mask;
    logic [COL_W-1:0] offs;

    // One mask bit per column bit: set when the bit belongs to the wrap field.
    for (genvar i = 0; i < COL_W; i++) begin : g_mask
        assign mask[i] = full || (i < int'(len_log));
    end

    // Form the column: fixed upper bits, counted lower bits.
    always_comb begin
        offs = ilv ? (base ^ cnt) : (base + cnt);
        col  = (base & ~mask) | (offs & mask);
    end

endmodule

// File: rtl/burst_col_seq.sv
// Module: SDRAM burst column address sequencer (top).
// Emits one column per clock for each read/write burst; supports fixed
// lengths 1/2/4/8, full-page with stop, interrupts, and single-beat writes.
// Assumes synchronous active-low reset and one command per clock at most.
module burst_col_seq
    import bcs_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_in,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic              stop_req,
    output logic [COL_W-1:0]  col_out,
    output logic              col_valid,
    output logic              col_last
);

    bcs_mode_t        mode_q;
    logic             active;
    logic             last;
    logic [COL_W-1:0] base;
    logic [COL_W-1:0] cnt;
    logic [1:0]       len_log;
    logic             full;
    logic             ilv;
    logic [COL_W-1:0] col;

    bcs_mode_reg u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_we (mode_we),
        .mode_in (mode_in),
        .mode_q  (mode_q)
    );

    bcs_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_q    (mode_q),
        .cmd_valid (cmd_valid),
        .cmd_write (cmd_write),
        .cmd_col   (cmd_col),
        .stop_req  (stop_req),
        .active    (active),
        .last      (last),
        .base      (base),
        .cnt       (cnt),
        .len_log   (len_log),
        .full      (full),
        .ilv       (ilv)
    );

    bcs_col_gen #(.COL_W(COL_W)) u_gen (
        .base    (base),
        .cnt     (cnt),
        .len_log (len_log),
        .full    (full),
        .ilv     (ilv),
        .col     (col)
    );

    // Drive outputs; column reads as zero while idle.
    always_comb begin
        col_valid = active;
        col_last  = active & last;
        col_out   = active ? col : '0;
    end

endmodule

// File: rtl/bcs_checker.sv
// Module: protocol checker for the burst column sequencer, bound to the top.
module bcs_checker #(
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [COL_W-1:0] cmd_col,
    input logic             stop_req,
    input logic [COL_W-1:0] col_out,
    input logic             col_valid,
    input logic             col_last
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !col_valid |-> (!col_last && col_out == '0)); // R1

    AST_LAST_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        col_last |-> col_valid); // R3

    AST_ENDS_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (col_last && !cmd_valid) |=> !col_valid); // R3

    AST_KEEPS_GOING: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && !col_last && !cmd_valid && !stop_req) |=> col_valid); // R6

    AST_CMD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> (col_valid && col_out == $past(cmd_col))); // R8

endmodule

bind burst_col_seq bcs_checker #(.COL_W(COL_W)) u_bcs_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_col   (cmd_col),
    .stop_req  (stop_req),
    .col_out   (col_out),
    .col_valid (col_valid),
    .col_last  (col_last)
);

// File: tb/burst_col_seq_bench.sv
// Bench: vector table of bursts, then directed corner tests.
module burst_col_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int COL_W      = 8;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             mode_we;
    logic [4:0]       mode_in;
    logic             cmd_valid;
    logic             cmd_write;
    logic [COL_W-1:0] cmd_col;
    logic             stop_req;
    logic [COL_W-1:0] col_out;
    logic             col_valid;
    logic             col_last;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_col_seq #(.COL_W(COL_W)) u_burst_col_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_we   (mode_we),
        .mode_in   (mode_in),
        .cmd_valid (cmd_valid),
        .cmd_write (cmd_write),
        .cmd_col   (cmd_col),
        .stop_req  (stop_req),
        .col_out   (col_out),
        .col_valid (col_valid),
        .col_last  (col_last)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [4:0]  mode;
        logic        wr;
        logic [7:0]  col;
        logic [3:0]  len;
        logic [63:0] cols;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        // R4 sequential len8, start 3
        '{4'd4, 5'b00011, 1'b0, 8'd3,   4'd8, {8'd3, 8'd4, 8'd5, 8'd6, 8'd7, 8'd0, 8'd1, 8'd2}},
        // R4 sequential len8, upper bits kept
        '{4'd4, 5'b00011, 1'b0, 8'd45,  4'd8, {8'd45, 8'd46, 8'd47, 8'd40, 8'd41, 8'd42, 8'd43, 8'd44}},
        // R4 sequential len4
        '{4'd4, 5'b00010, 1'b0, 8'd22,  4'd4, {8'd22, 8'd23, 8'd20, 8'd21, 32'd0}},
        // R4 sequential len4 at top column
        '{4'd4, 5'b00010, 1'b1, 8'd255, 4'd4, {8'd255, 8'd252, 8'd253, 8'd254, 32'd0}},
        // R4 sequential len2
        '{4'd4, 5'b00001, 1'b0, 8'd5,   4'd2, {8'd5, 8'd4, 48'd0}},
        // R5 interleaved len8, start 0 ascending
        '{4'd5, 5'b01011, 1'b0, 8'd0,   4'd8, {8'd0, 8'd1, 8'd2, 8'd3, 8'd4, 8'd5, 8'd6, 8'd7}},
        // R5 interleaved len8, start 7 descending
        '{4'd5, 5'b01011, 1'b0, 8'd7,   4'd8, {8'd7, 8'd6, 8'd5, 8'd4, 8'd3, 8'd2, 8'd1, 8'd0}},
        // R5 interleaved len8, start 18
        '{4'd5, 5'b01011, 1'b1, 8'd18,  4'd8, {8'd18, 8'd19, 8'd16, 8'd17, 8'd22, 8'd23, 8'd20, 8'd21}},
        // R5 interleaved len4, start 49
        '{4'd5, 5'b01010, 1'b0, 8'd49,  4'd4, {8'd49, 8'd48, 8'd51, 8'd50, 32'd0}},
        // R5 interleaved len2 equals sequential
        '{4'd5, 5'b01001, 1'b0, 8'd5,   4'd2, {8'd5, 8'd4, 48'd0}},
        // R2 length 1
        '{4'd2, 5'b00000, 1'b0, 8'd154, 4'd1, {8'd154, 56'd0}},
        // R2 reserved 100
        '{4'd2, 5'b00100, 1'b0, 8'd64,  4'd1, {8'd64, 56'd0}},
        // R2 reserved 101
        '{4'd2, 5'b01101, 1'b0, 8'd65,  4'd1, {8'd65, 56'd0}},
        // R2 reserved 110
        '{4'd2, 5'b00110, 1'b1, 8'd66,  4'd1, {8'd66, 56'd0}},
        // R9 write single: write is one beat
        '{4'd9, 5'b10011, 1'b1, 8'd3,   4'd1, {8'd3, 56'd0}},
        // R9 write single: read keeps len8
        '{4'd9, 5'b10011, 1'b0, 8'd3,   4'd8, {8'd3, 8'd4, 8'd5, 8'd6, 8'd7, 8'd0, 8'd1, 8'd2}},
        // R3 plain write len4 without single option
        '{4'd3, 5'b00010, 1'b1, 8'd9,   4'd4, {8'd9, 8'd10, 8'd11, 8'd8, 32'd0}}
    };

    // Record one check; print FAIL with actual and expected on mismatch.
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] obs();
        return {22'd0, col_valid, col_last, col_out};
    endfunction

    task automatic beat(input string req, input logic [7:0] col, input logic last);
        chk(req, obs(), {22'd0, 1'b1, last, col});
    endtask

    task automatic idle(input string req);
        chk(req, obs(), 32'd0);
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic load_mode(input logic [4:0] m);
        mode_we = 1'b1;
        mode_in = m;
        step();
        mode_we = 1'b0;
    endtask

    // Present a command for one edge; returns when beat 0 is visible.
    task automatic issue(input logic wr, input logic [7:0] col);
        cmd_valid = 1'b1;
        cmd_write = wr;
        cmd_col   = col;
        step();
        cmd_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; mode_we = 1'b0; mode_in = '0; cmd_valid = 1'b0;
        cmd_write = 1'b0; cmd_col = '0; stop_req = 1'b0;
        step(); step();
        idle("R1 reset state");
        rst_n = 1'b1;
        step();

        // Vector table walk.
        for (int v = 0; v < NV; v++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VECS[v].req, v);
            load_mode(VECS[v].mode);
            issue(VECS[v].wr, VECS[v].col);
            for (int b = 0; b < int'(VECS[v].len); b++) begin
                beat(tag, VECS[v].cols[63-8*b -: 8], b == int'(VECS[v].len) - 1);
                step();
            end
            idle({tag, " end"});
        end

        // R6 full page wraps past the top, no last; R7 stop ends it.
        load_mode(5'b00111);
        issue(1'b0, 8'd253);
        beat("R6 fp", 8'd253, 1'b0); step();
        beat("R6 fp", 8'd254, 1'b0); step();
        beat("R6 fp", 8'd255, 1'b0); step();
        beat("R6 fp wrap", 8'd0, 1'b0); step();
        beat("R6 fp", 8'd1, 1'b0);
        stop_req = 1'b1; step(); stop_req = 1'b0;
        idle("R7 stop in full page");

        // R6 full page ignores interleave; R8 interrupt by command.
        load_mode(5'b01111);
        issue(1'b0, 8'd6);
        beat("R6 fp ilv", 8'd6, 1'b0); step();
        beat("R6 fp ilv", 8'd7, 1'b0); step();
        beat("R6 fp ilv", 8'd8, 1'b0);
        issue(1'b0, 8'd100);
        beat("R8 fp interrupt", 8'd100, 1'b0); step();
        beat("R8 fp interrupt", 8'd101, 1'b0);
        stop_req = 1'b1; step(); stop_req = 1'b0;
        idle("R7 stop after interrupt");

        // R7 stop ignored in fixed burst.
        load_mode(5'b00010);
        issue(1'b0, 8'h20);
        beat("R7 ignore", 8'h20, 1'b0);
        stop_req = 1'b1; step(); stop_req = 1'b0;
        beat("R7 ignore", 8'h21, 1'b0); step();
        beat("R7 ignore", 8'h22, 1'b0); step();
        beat("R7 ignore", 8'h23, 1'b1); step();
        idle("R7 ignore end");

        // R8 interrupt of fixed burst runs the full new burst.
        load_mode(5'b00011);
        issue(1'b0, 8'd0);
        beat("R8 int", 8'd0, 1'b0); step();
        beat("R8 int", 8'd1, 1'b0);
        issue(1'b1, 8'h50);
        for (int k = 0; k < 8; k++) begin
            beat("R8 new burst", 8'h50 + 8'(k), k == 7);
            step();
        end
        idle("R8 new burst end");

        // R8 back-to-back commands on consecutive cycles.
        cmd_valid = 1'b1; cmd_write = 1'b0; cmd_col = 8'd10;
        step();
        beat("R8 b2b", 8'd10, 1'b0);
        cmd_col = 8'd20; step();
        beat("R8 b2b", 8'd20, 1'b0);
        cmd_col = 8'd30; step();
        cmd_valid = 1'b0;
        beat("R8 b2b", 8'd30, 1'b0); step();
        beat("R8 b2b", 8'd31, 1'b0);

        // R1 reset in the middle of a burst.
        rst_n = 1'b0; step(); rst_n = 1'b1;
        idle("R1 mid-burst reset");

        // R10 mode load during a burst does not change it.
        load_mode(5'b00011);
        issue(1'b0, 8'd0);
        beat("R10 running", 8'd0, 1'b0);
        mode_we = 1'b1; mode_in = 5'b00001; step(); mode_we = 1'b0;
        for (int k = 1; k < 8; k++) begin
            beat("R10 running", 8'(k), k == 7);
            step();
        end
        idle("R10 running end");
        issue(1'b0, 8'd4);
        beat("R10 new mode", 8'd4, 1'b0); step();
        beat("R10 new mode", 8'd5, 1'b1); step();
        idle("R10 new mode end");

        // R10 load at the same edge as a command: command uses old mode.
        mode_we = 1'b1; mode_in = 5'b00000;
        cmd_valid = 1'b1; cmd_write = 1'b0; cmd_col = 8'h60;
        step();
        mode_we = 1'b0; cmd_valid = 1'b0;
        beat("R10 same edge", 8'h60, 1'b0); step();
        beat("R10 same edge", 8'h61, 1'b1); step();
        idle("R10 same edge end");
        issue(1'b0, 8'h60);
        beat("R10 after load", 8'h60, 1'b1); step();
        idle("R10 after load end");

        // R9 write single with full-page reads.
        load_mode(5'b10111);
        issue(1'b1, 8'h10);
        beat("R9 fp write", 8'h10, 1'b1); step();
        idle("R9 fp write end");
        issue(1'b0, 8'h10);
        beat("R9 fp read", 8'h10, 1'b0); step();
        beat("R9 fp read", 8'h11, 1'b0);
        stop_req = 1'b1; step(); stop_req = 1'b0;
        idle("R9 fp read stopped");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule